// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits in front of a shared two-port memory and watches both access ports. Each port brings an active-low enable, a word address, an active-low write strobe, an active-low output enable and an active-low per-lane write mask. When both ports select the same word in the same cycle, the block picks one port to go ahead. The other port gets an active-low busy flag, and its write strobes are held off so the memory is never written by the losing side.

The decision is registered and uses only enables and addresses. A port that has held its enabled address for at least one cycle beats a port that has just arrived. Two ports arriving in the same cycle are settled by a fixed rule that favours the left port. The winner is kept for as long as both ports stay on the shared word. In master mode the block drives both busy flags. In slave mode the flags are held high and the two busy inputs act only as write inhibits, one per side. This lets one master arbiter steer the busy inputs of any number of slave lanes. All lanes of one port are always inhibited together.

Top module: `dpc_arbiter`

## Requirements
- R1: While `rst` is high, and after the first edge with `rst` high, both busy outputs, every write strobe output and both read strobe outputs are 1 (inactive).
- R2: If either port's enable is 1 (inactive) at a clock edge, both busy outputs are 1 after that edge.
- R3: When both ports are enabled on the same address, and the right port was already enabled on that address at the previous edge while the left port was not, `l_busy_n` is 0 and `r_busy_n` is 1 after the edge.
- R4: In the mirror case of R3 (left port already settled, right port new), `r_busy_n` is 0 and `l_busy_n` is 1.
- R5: When both ports arrive on the same address at the same edge, the left port wins and `r_busy_n` goes to 0.
- R6: The two busy outputs are never 0 at the same time.
- R7: While both enables stay active on matching addresses, the port that lost keeps its busy output at 0.
- R8: Busy returns to 1 on the first edge at which the addresses differ or either enable is inactive.
- R9: The write and output-enable inputs have no effect on which port is flagged busy.
- R10: A port whose busy is 0 (master mode) or whose busy input is 0 (slave mode) has all its write strobe outputs at 1. The port that wins still writes.
- R11: The read strobe output of a port is 0 exactly when its enable and output enable are 0 and its write input is 1, one cycle later, whatever the busy state.
- R12: With `master_mode` at 0, both busy outputs are 1. A busy input at 0 blocks writes only on its own side, and a busy input at 1 leaves writes alone. With `master_mode` at 1, the busy inputs are ignored.
- R13: Write strobe output bit i of a port is 0 only when lane-mask bit i of that port is 0, in addition to the conditions above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = generate busy, 0 = busy inputs only inhibit writes |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_lane_n | input | LANES | Left port per-lane write mask, active low |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| r_lane_n | input | LANES | Right port per-lane write mask, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| l_we_n | output | LANES | Left gated lane write strobes, active low, registered |
| r_we_n | output | LANES | Right gated lane write strobes, active low, registered |
| l_rd_n | output | 1 | Left read strobe, active low, registered |
| r_rd_n | output | 1 | Right read strobe, active low, registered |

## Verification
The properties assume that `master_mode` does not change while a collision is active. They also assume that the slave-mode busy inputs are only meaningful while `master_mode` is 0. The bench changes the mode only after a cycle in which both ports are idle. Every stimulus change is made on the falling edge, so each port's enable and address are stable across the rising edge that classifies them as settled or newly arrived. Collision sequences are always separated by idle cycles, so a stale winner never carries into a new pairing.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  typedef struct packed {
    logic active;   // enable asserted this cycle
    logic settled;  // same enabled address as at the previous edge
  } port_view_t;

endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track #(
  parameter int ADDR_W = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_n,
  input  logic [ADDR_W-1:0]    addr,
  output dpc_pkg::port_view_t  view
);

  logic              prev_act_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_act_q  <= ~en_n;
      prev_addr_q <= addr;
    end
  end

  always_comb begin
    view.active  = ~en_n;
    view.settled = ~en_n & prev_act_q & (prev_addr_q == addr);
  end

endmodule

// File: rtl/dpc_decide.sv
module dpc_decide #(
  parameter int ADDR_W = 13
) (
  input  dpc_pkg::port_view_t l_view,
  input  dpc_pkg::port_view_t r_view,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic [ADDR_W-1:0]   r_addr,
  input  dpc_pkg::owner_t     owner_q,
  output dpc_pkg::owner_t     owner_d
);
  import dpc_pkg::*;

  logic same_word;
  logic keep_winner;

  always_comb begin
    same_word   = l_view.active & r_view.active & (l_addr == r_addr);
    keep_winner = (owner_q != OWN_NONE) & l_view.settled & r_view.settled;
    if (!same_word) begin
      owner_d = OWN_NONE;
    end else if (keep_winner) begin
      owner_d = owner_q;
    end else if (r_view.settled && !l_view.settled) begin
      owner_d = OWN_RIGHT;
    end else begin
      // left settled first, or a tie in the same cycle: left wins
      owner_d = OWN_LEFT;
    end
  end

endmodule

// File: rtl/dpc_strobe_gate.sv
module dpc_strobe_gate #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             inhibit,
  output logic [LANES-1:0] we_n,
  output logic             rd_n
);

  logic write_ok;

  always_comb write_ok = ~en_n & ~wr_n & ~inhibit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) we_n[g] <= 1'b1;
      else     we_n[g] <= ~(write_ok & ~lane_n[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_n <= 1'b1;
    else     rd_n <= en_n | oe_n | ~wr_n;
  end

endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
  parameter int ADDR_W = 13,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_en_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [LANES-1:0]  l_lane_n,
  input  logic              l_busy_in_n,
  input  logic              r_en_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [LANES-1:0]  r_lane_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic [LANES-1:0]  l_we_n,
  output logic [LANES-1:0]  r_we_n,
  output logic              l_rd_n,
  output logic              r_rd_n
);
  import dpc_pkg::*;

  port_view_t l_view, r_view;
  owner_t     owner_q, owner_d;
  logic       l_lose, r_lose;
  logic       l_block, r_block;

  dpc_port_track #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst(rst), .en_n(l_en_n), .addr(l_addr), .view(l_view)
  );

  dpc_port_track #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst(rst), .en_n(r_en_n), .addr(r_addr), .view(r_view)
  );

  dpc_decide #(.ADDR_W(ADDR_W)) u_decide (
    .l_view(l_view), .r_view(r_view),
    .l_addr(l_addr), .r_addr(r_addr),
    .owner_q(owner_q), .owner_d(owner_d)
  );

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_d;
  end

  always_comb begin
    l_lose  = master_mode & (owner_d == OWN_RIGHT);
    r_lose  = master_mode & (owner_d == OWN_LEFT);
    l_block = master_mode ? l_lose : ~l_busy_in_n;
    r_block = master_mode ? r_lose : ~r_busy_in_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      l_busy_n <= ~l_lose;
      r_busy_n <= ~r_lose;
    end
  end

  dpc_strobe_gate #(.LANES(LANES)) u_gate_l (
    .clk(clk), .rst(rst), .en_n(l_en_n), .wr_n(l_wr_n), .oe_n(l_oe_n),
    .lane_n(l_lane_n), .inhibit(l_block), .we_n(l_we_n), .rd_n(l_rd_n)
  );

  dpc_strobe_gate #(.LANES(LANES)) u_gate_r (
    .clk(clk), .rst(rst), .en_n(r_en_n), .wr_n(r_wr_n), .oe_n(r_oe_n),
    .lane_n(r_lane_n), .inhibit(r_block), .we_n(r_we_n), .rd_n(r_rd_n)
  );

endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
  parameter int ADDR_W = 13,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              l_en_n,
  input logic              r_en_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic [LANES-1:0]  l_we_n,
  input logic [LANES-1:0]  r_we_n
);

  p_one_loser_r6: assert property (@(posedge clk) disable iff (rst)
    l_busy_n || r_busy_n);

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (l_en_n || r_en_n) |=> (l_busy_n && r_busy_n));

  p_hold_loser_r7: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !r_busy_n && !l_en_n && !r_en_n && (l_addr == r_addr))
      |=> !r_busy_n);

  p_gate_left_r10: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> (&l_we_n));

  p_gate_right_r10: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> (&r_we_n));

  p_slave_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (l_busy_n && r_busy_n));

  p_slave_inhibit_r12: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !l_busy_in_n) |=> (&l_we_n));

  p_slave_inhibit_b_r12: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !r_busy_in_n) |=> (&r_we_n));

endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode),
  .l_en_n(l_en_n), .r_en_n(r_en_n), .l_addr(l_addr), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_we_n(l_we_n), .r_we_n(r_we_n)
);

// File: tb/test_dpc_arbiter.sv
module test_dpc_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int LANES  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic l_en_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1, l_busy_in_n = 1'b1;
  logic r_en_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1, r_busy_in_n = 1'b1;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [LANES-1:0]  l_lane_n = '0, r_lane_n = '0;
  logic l_busy_n, r_busy_n, l_rd_n, r_rd_n;
  logic [LANES-1:0] l_we_n, r_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpc_arbiter #(.ADDR_W(ADDR_W), .LANES(LANES)) i_dpc_arbiter (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_lane_n(l_lane_n), .l_busy_in_n(l_busy_in_n),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_lane_n(r_lane_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_we_n(l_we_n), .r_we_n(r_we_n), .l_rd_n(l_rd_n), .r_rd_n(r_rd_n)
  );

  typedef struct {
    logic lb, rb;
    logic [LANES-1:0] lwe, rwe;
    logic lrd, rrd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares one expected item after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "l_busy_n", {7'd0, l_busy_n}, {7'd0, e.lb});
      chk(e.tag, "r_busy_n", {7'd0, r_busy_n}, {7'd0, e.rb});
      chk(e.tag, "l_we_n", 8'(l_we_n), 8'(e.lwe));
      chk(e.tag, "r_we_n", 8'(r_we_n), 8'(e.rwe));
      chk(e.tag, "l_rd_n", {7'd0, l_rd_n}, {7'd0, e.lrd});
      chk(e.tag, "r_rd_n", {7'd0, r_rd_n}, {7'd0, e.rrd});
    end
  end

  // port setting: en, wr, oe are active-low values
  task automatic set_l(logic en, logic wr, logic oe, int a);
    l_en_n = en; l_wr_n = wr; l_oe_n = oe; l_addr = ADDR_W'(a);
  endtask
  task automatic set_r(logic en, logic wr, logic oe, int a);
    r_en_n = en; r_wr_n = wr; r_oe_n = oe; r_addr = ADDR_W'(a);
  endtask

  // driver: inputs already set at the falling edge; queue the expectation
  task automatic push(string tag, logic lb, logic rb, logic [LANES-1:0] lwe,
                      logic [LANES-1:0] rwe, logic lrd, logic rrd);
    exp_t e;
    e.tag = tag; e.lb = lb; e.rb = rb; e.lwe = lwe; e.rwe = rwe;
    e.lrd = lrd; e.rrd = rrd;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    set_l(1, 1, 1, 0); set_r(1, 1, 1, 0);
    push("idle", 1, 1, 2'b11, 2'b11, 1, 1);
  endtask

  initial begin
    // R1: reset state
    @(negedge clk); push("R1 reset", 1, 1, 2'b11, 2'b11, 1, 1);
    @(negedge clk); push("R1 reset", 1, 1, 2'b11, 2'b11, 1, 1);
    @(negedge clk); rst = 1'b0;
    set_l(0, 0, 1, 5);
    push("R2 left alone writes", 1, 1, 2'b00, 2'b11, 1, 1);
    @(negedge clk); set_r(0, 1, 0, 5);
    push("R4 R11 left settled wins", 1, 0, 2'b00, 2'b11, 1, 0);
    @(negedge clk); set_r(0, 0, 1, 5);
    push("R7 R10 right write gated", 1, 0, 2'b00, 2'b11, 1, 1);
    @(negedge clk); set_r(0, 0, 1, 6);
    push("R8 address differs", 1, 1, 2'b00, 2'b00, 1, 1);
    idle();
    @(negedge clk); set_r(0, 1, 0, 9);
    push("R2 right alone reads", 1, 1, 2'b11, 2'b11, 1, 0);
    @(negedge clk); set_l(0, 0, 1, 9);
    push("R3 R10 right settled wins", 0, 1, 2'b11, 2'b11, 1, 0);
    @(negedge clk); set_l(1, 0, 1, 9);
    push("R8 R2 left enable drops", 1, 1, 2'b11, 2'b11, 1, 0);
    idle();
    @(negedge clk); set_l(0, 0, 1, 12); set_r(0, 0, 1, 12);
    push("R5 tie left wins", 1, 0, 2'b00, 2'b11, 1, 1);
    @(negedge clk); set_l(0, 1, 0, 12); set_r(0, 1, 0, 12);
    push("R9 R7 reads keep winner", 1, 0, 2'b11, 2'b11, 0, 0);
    idle();
    @(negedge clk); set_l(0, 1, 0, 3); set_r(0, 1, 0, 3);
    push("R9 read tie still arbitrates", 1, 0, 2'b11, 2'b11, 0, 0);
    idle();
    @(negedge clk); set_l(0, 0, 1, 20); l_lane_n = 2'b10;
    push("R13 lane mask", 1, 1, 2'b10, 2'b11, 1, 1);
    idle();
    l_lane_n = 2'b00;
    // R12: slave mode
    @(negedge clk); master_mode = 1'b0;
    set_l(0, 0, 1, 7); set_r(0, 0, 1, 7);
    push("R12 slave no busy", 1, 1, 2'b00, 2'b00, 1, 1);
    @(negedge clk); l_busy_in_n = 1'b0;
    push("R12 slave left inhibit", 1, 1, 2'b11, 2'b00, 1, 1);
    @(negedge clk); l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
    push("R12 slave right inhibit", 1, 1, 2'b00, 2'b11, 1, 1);
    @(negedge clk); set_l(1, 1, 1, 0); set_r(1, 1, 1, 0);
    push("idle", 1, 1, 2'b11, 2'b11, 1, 1);
    @(negedge clk); master_mode = 1'b1; l_busy_in_n = 1'b0; r_busy_in_n = 1'b0;
    set_l(0, 0, 1, 1);
    push("R12 master ignores busy inputs", 1, 1, 2'b00, 2'b11, 1, 1);
    idle();
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule